// File: doc/BRIEF.md
# Link Self-Test Loop Generator and Checker

This block runs a built-in self-test over a character link at the decoded level. Its transmit half emits a repeating test loop: one start marker (the K28.5 control character) followed by a fixed run of pseudo-random data bytes. Its receive half watches the characters that come back from the far end, looks for the marker, then compares each following character against its own copy of the sequence and reports a 3-bit status code per character.

Each half has its own enable. Dropping an enable puts that half back at the beginning of the loop. The transmit half raises a completion flag for one character period on the final character of each loop. The interface is an 8-bit byte plus a control (K) flag in each direction. Serialisation and line coding sit outside the block, and both halves share one character clock.

Top module: `bist_loop`

## Requirements
- R1: While `tx_en` is low, `tx_data`, `tx_k` and `tx_done` are all 0. In the first cycle `tx_en` is high, the marker appears: `tx_k`=1 and `tx_data`=8'hBC.
- R2: Each marker is followed by 511 data characters with `tx_k`=0. A 9-bit register starts at 9'h1FF and supplies each byte from its bits [7:0]. After every data character the register shifts left by one, and bit 8 XOR bit 4 enters at bit 0 (polynomial x^9+x^5+1). The first data byte is therefore 8'hFF.
- R3: After the 511th data character the marker is sent again, and the data run restarts from 9'h1FF.
- R4: `tx_done` is high only in the cycle that presents the 511th data character, so it lasts exactly one character period per loop.
- R5: `rx_status` is registered and describes the character sampled on the previous rising edge. The codes are: 3'b000 for a correct marker or a correct mid-loop data character, and 3'b010 for a correct 511th data character.
- R6: While hunting, any character that is not the marker (K=1 with byte 8'hBC) gives status 3'b100.
- R7: In the data run, a byte mismatch or a K flag set to 1 gives status 3'b100, and the checker returns to hunting. That character is consumed and is not itself taken as a marker.
- R8: While `rx_en` is low, the status is 3'b100 on the following cycle and the checker is put back into hunting. A low `tx_en` returns the generator to the marker.
- R9: While `rst_n` is low, `rx_status` is 3'b100 and the generator sits at the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Enable for the generator |
| tx_data | output | 8 | Generated character byte |
| tx_k | output | 1 | Generated character is a control character |
| tx_done | output | 1 | High on the final character of a loop |
| rx_en | input | 1 | Enable for the checker |
| rx_data | input | 8 | Received character byte |
| rx_k | input | 1 | Received character is a control character |
| rx_status | output | 3 | Per-character check status |

## Verification
The generator outputs are combinational from its state, so they are due in the same cycle that `tx_en` is applied. The bench compares them a moment after driving on the falling edge. The checker status is due one cycle after the character it judges. The driver pushes each expected code into a queue, and the monitor pops and compares it on the next falling edge, after the intervening rising edge has registered it. The runs cover full loops, a corrupted byte, a corrupted K flag, a checker pause and a generator restart mid-loop. In each case the status must fall to hunting and recover only at the following marker.

// File: rtl/bist_loop.sv
module bist_loop #(
  parameter int          LFSR_W = 9,
  parameter int          TAP    = 5,
  parameter logic [8:0]  SEED   = 9'h1FF,
  parameter logic [7:0]  MARKER = 8'hBC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  output logic [7:0] tx_data,
  output logic       tx_k,
  output logic       tx_done,
  input  logic       rx_en,
  input  logic [7:0] rx_data,
  input  logic       rx_k,
  output logic [2:0] rx_status
);
  localparam int             LOOP_LEN = (1 << LFSR_W) - 1;
  localparam logic [LFSR_W-1:0] LAST  = LFSR_W'(LOOP_LEN - 1);
  localparam logic [LFSR_W-1:0] INIT  = LFSR_W'(SEED);
  localparam logic [2:0] ST_HUNT = 3'b100;
  localparam logic [2:0] ST_OK   = 3'b000;
  localparam logic [2:0] ST_LAST = 3'b010;

  function automatic logic [LFSR_W-1:0] adv(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP-1]};
  endfunction

  // generator
  logic              tx_mark;
  logic [LFSR_W-1:0] tx_lfsr, tx_cnt;
  wire tx_last = !tx_mark && (tx_cnt == LAST);

  assign tx_k    = tx_en && tx_mark;
  assign tx_data = !tx_en ? 8'h00 : (tx_mark ? MARKER : tx_lfsr[7:0]);
  assign tx_done = tx_en && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mark <= 1'b1;
      tx_lfsr <= INIT;
      tx_cnt  <= '0;
    end else if (!tx_en) begin
      tx_mark <= 1'b1;
      tx_lfsr <= INIT;
      tx_cnt  <= '0;
    end else if (tx_mark) begin
      tx_mark <= 1'b0;
      tx_lfsr <= INIT;
      tx_cnt  <= '0;
    end else if (tx_last) begin
      tx_mark <= 1'b1;
      tx_lfsr <= INIT;
      tx_cnt  <= '0;
    end else begin
      tx_lfsr <= adv(tx_lfsr);
      tx_cnt  <= tx_cnt + 1'b1;
    end
  end

  // checker
  logic              rx_lock;
  logic [LFSR_W-1:0] rx_lfsr, rx_cnt;
  wire rx_is_mark = rx_k && (rx_data == MARKER);
  wire rx_match   = !rx_k && (rx_data == rx_lfsr[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lock   <= 1'b0;
      rx_lfsr   <= INIT;
      rx_cnt    <= '0;
      rx_status <= ST_HUNT;
    end else if (!rx_en) begin
      rx_lock   <= 1'b0;
      rx_status <= ST_HUNT;
    end else if (!rx_lock) begin
      if (rx_is_mark) begin
        rx_lock   <= 1'b1;
        rx_lfsr   <= INIT;
        rx_cnt    <= '0;
        rx_status <= ST_OK;
      end else begin
        rx_status <= ST_HUNT;
      end
    end else if (!rx_match) begin
      rx_lock   <= 1'b0;
      rx_status <= ST_HUNT;
    end else if (rx_cnt == LAST) begin
      rx_lock   <= 1'b0;
      rx_status <= ST_LAST;
    end else begin
      rx_lfsr   <= adv(rx_lfsr);
      rx_cnt    <= rx_cnt + 1'b1;
      rx_status <= ST_OK;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (tx_data == 8'h00 && !tx_k && !tx_done));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  a_r3_marker_after_loop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!tx_en || (tx_k && tx_data == MARKER)));
  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rx_status == ST_HUNT || rx_status == ST_OK || rx_status == ST_LAST);
  a_r6_no_last_while_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_lock) |=> rx_status != ST_LAST);
  a_r7_mismatch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_lock && !rx_match) |=> (rx_status == ST_HUNT && !rx_lock));
  a_r8_rx_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> rx_status == ST_HUNT);
endmodule

// File: tb/bist_loop_bench.sv
module bist_loop_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic [7:0] tx_data, rx_data = 8'h00;
  logic       tx_k, tx_done, rx_k = 1'b0;
  logic [2:0] rx_status;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  logic [2:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_loop u_bist_loop (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data), .tx_k(tx_k),
    .tx_done(tx_done), .rx_en(rx_en), .rx_data(rx_data), .rx_k(rx_k),
    .rx_status(rx_status));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // models built from the requirements
  bit       m_tmark = 1'b1;
  bit [8:0] m_tlfsr = 9'h1FF;
  int       m_tcnt  = 0;
  bit       m_rlock = 1'b0;
  bit [8:0] m_rlfsr = 9'h1FF;
  int       m_rcnt  = 0;

  function automatic bit [8:0] nxt(input bit [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  // monitor: status for the previous character
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      automatic logic [2:0] e = q_exp.pop_front();
      automatic string t = q_tag.pop_front();
      check(t, int'(rx_status), int'(e));
    end
  end

  // corrupt: 0 none, 1 flip byte bit 0, 2 force K flag
  task automatic step(input bit te, input bit re, input int corrupt);
    logic [7:0] ed;
    bit ek, edone;
    logic [7:0] rd;
    bit rk;
    @(negedge clk);
    tx_en = te;
    rx_en = re;
    #1;
    if (!te) begin ed = 8'h00; ek = 0; edone = 0; end
    else if (m_tmark) begin ed = 8'hBC; ek = 1; edone = 0; end
    else begin ed = m_tlfsr[7:0]; ek = 0; edone = (m_tcnt == 510); end
    if (!te) check("R1 idle data", int'(tx_data), 0);
    else if (ek) check("R3 marker byte", int'(tx_data), int'(ed));
    else check("R2 data byte", int'(tx_data), int'(ed));
    check(ek ? "R1 marker K" : "R2 K flag", int'(tx_k), int'(ek));
    check("R4 loop done", int'(tx_done), int'(edone));
    rd = tx_data; rk = tx_k;
    if (corrupt == 1) rd[0] = ~rd[0];
    if (corrupt == 2) rk = 1'b1;
    rx_data = rd; rx_k = rk;
    // generator model advance
    if (!te || m_tmark) begin m_tmark = !te; m_tlfsr = 9'h1FF; m_tcnt = 0; end
    else if (m_tcnt == 510) begin m_tmark = 1; m_tlfsr = 9'h1FF; m_tcnt = 0; end
    else begin m_tlfsr = nxt(m_tlfsr); m_tcnt++; end
    // checker model
    if (!re) begin
      m_rlock = 0; q_exp.push_back(3'b100); q_tag.push_back("R8 rx disabled");
    end else if (!m_rlock) begin
      if (rk && rd == 8'hBC) begin
        m_rlock = 1; m_rlfsr = 9'h1FF; m_rcnt = 0;
        q_exp.push_back(3'b000); q_tag.push_back("R5 marker found");
      end else begin
        q_exp.push_back(3'b100); q_tag.push_back("R6 hunting");
      end
    end else if (rk || rd != m_rlfsr[7:0]) begin
      m_rlock = 0; q_exp.push_back(3'b100); q_tag.push_back("R7 mismatch");
    end else if (m_rcnt == 510) begin
      m_rlock = 0; q_exp.push_back(3'b010); q_tag.push_back("R5 last valid");
    end else begin
      m_rlfsr = nxt(m_rlfsr); m_rcnt++;
      q_exp.push_back(3'b000); q_tag.push_back("R5 mid match");
    end
  endtask

  task automatic run(input int n, input bit te, input bit re);
    for (int i = 0; i < n; i++) step(te, re, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset status", int'(rx_status), 3'b100);
    check("R9 reset tx_k", int'(tx_k), 0);
    check("R1 reset data", int'(tx_data), 0);
    rst_n = 1'b1;
    run(4, 0, 0);
    run(1100, 1, 1);
    run(100, 1, 1);
    step(1, 1, 1);
    run(600, 1, 1);
    run(50, 1, 1);
    step(1, 1, 2);
    run(600, 1, 1);
    run(20, 1, 0);
    run(600, 1, 1);
    run(5, 0, 1);
    run(1100, 1, 1);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule